// File: doc/BRIEF.md
# General-Purpose Pin Bank with Wake-Event Routing

This block manages sixteen general-purpose pins behind a simple register read/write port. Each pin can be an input or an output. An output pin drives its pad in push-pull, open-drain or high-impedance fashion. A per-pin lock, once set, freezes that pin's direction, drive type and output data until the next reset.

Fifteen of the pins (indices 0 to 14) also act as event sources. Each source has a programmable polarity and a choice between edge and level detection. Incoming pin values pass through a two-flop synchroniser before detection. Edge events set a sticky status bit that software clears by writing 1. A level event's status bit tracks the active level. Three separate enable masks steer the status bits onto an interrupt output, a system-management interrupt output and a wake output. Each of these outputs is the OR of the status bits that its mask enables.

Register map (4-bit address, 16-bit data, one bit per pin): 0 direction (1 = output), 1 data, 2 drive select A, 3 drive select B, 4 lock, 5 polarity, 6 trigger (1 = edge), 7 IRQ enable, 8 SMI enable, 9 wake enable, 10 event status. Other addresses read as zero and ignore writes. Reads are combinational from the address.

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset, every register reads 0, `gpio_oe` and `gpio_out` are 0, and `irq_o`, `smi_o` and `pme_o` are 0.
- R2: A pin whose direction bit is 0 never drives (`gpio_oe` bit is 0). A pin whose direction bit is 1 drives according to its drive type.
- R3: The drive type of an output pin is {select B, select A}. 00 is push-pull: `gpio_oe`=1 and `gpio_out`=data. 01 is open-drain: `gpio_oe`=~data and `gpio_out`=0. 1x is high-impedance: `gpio_oe`=0. `gpio_out` is 0 in every mode other than push-pull.
- R4: Writing 1 to a lock bit sets it, and writing 0 leaves it unchanged. Only reset clears it. While a pin's lock bit is set, writes leave that pin's direction, data and both drive-select bits unchanged.
- R5: Reading the data register returns the output latch for output pins and the synchronised pin value for input pins. A pin change is visible two clock edges after it is applied.
- R6: With trigger=1, a pin moving into its active state sets its status bit on the third clock edge after the change. The active state is high when polarity=0 and low when polarity=1. A polarity change that makes the synchronised pin newly active also counts as an edge.
- R7: An edge status bit stays set until 1 is written to it at address 10. Writing 0 has no effect.
- R8: With trigger=0, the status bit equals the active level of the synchronised pin, one edge later, and a clear write has no lasting effect on it.
- R9: `irq_o`, `smi_o` and `pme_o` each equal the OR over sources of status AND the matching enable (addresses 7, 8 and 9).
- R10: Pin 15 is not an event source. Its status, polarity, trigger and enable bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data, one bit per pin |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| gpio_in | input | 16 | Pad input values (asynchronous) |
| gpio_out | output | 16 | Pad output values |
| gpio_oe | output | 16 | Pad output enables |
| irq_o | output | 1 | Routed interrupt request |
| smi_o | output | 1 | Routed system-management interrupt |
| pme_o | output | 1 | Routed wake request |

## Verification
A broken lock or configuration bit shows up on `gpio_oe` or `gpio_out` in the cycle after the offending write. It also shows up in the register read-back straight away. A detector fault, such as a missed edge, a wrong polarity or a status bit that decays, reaches `irq_o`, `smi_o` or `pme_o` three edges after the pin moves, provided a routing enable is set. It shows in the status register at the same time. Because the routing outputs and read-backs are combinational, the bench compares every output after each operation has settled. A divergence is therefore reported within one operation of its cause.

// File: rtl/gpio_wake_pkg.sv
// Shared definitions for the pin bank: register selector codes and drive modes.
// Assumes a 4-bit register address; codes not listed decode to nothing.
package gpio_wake_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RS_DIR    = 4'd0,
        RS_DATA   = 4'd1,
        RS_DRVA   = 4'd2,
        RS_DRVB   = 4'd3,
        RS_LOCK   = 4'd4,
        RS_POL    = 4'd5,
        RS_TRIG   = 4'd6,
        RS_IRQEN  = 4'd7,
        RS_SMIEN  = 4'd8,
        RS_PMEEN  = 4'd9,
        RS_STATUS = 4'd10
    } reg_sel_e;

    typedef enum logic [1:0] {
        DRV_PUSH  = 2'b00,
        DRV_OPEN  = 2'b01,
        DRV_OFF_A = 2'b10,
        DRV_OFF_B = 2'b11
    } drv_mode_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no bus coherence is provided.
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    // Purpose: resample the pads twice to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
// Per-pin output configuration: direction, data latch, drive selects and lock.
// Assumes a single-cycle write strobe; a set lock bit masks writes to the
// direction, data and drive bits of that pin until reset.
module gpio_cfg_regs
    import gpio_wake_pkg::*;
#(
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      data_q,
    output logic [N-1:0]      drva_q,
    output logic [N-1:0]      drvb_q,
    output logic [N-1:0]      lock_q
);
    logic [N-1:0] open_mask;
    reg_sel_e     sel;

    assign sel       = reg_sel_e'(addr);
    assign open_mask = ~lock_q;

    // Purpose: hold the lockable output configuration of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
            drva_q <= '0;
            drvb_q <= '0;
            lock_q <= '0;
        end else if (wr_en) begin
            case (sel)
                RS_DIR:  dir_q  <= (dir_q  & lock_q) | (wdata & open_mask);
                RS_DATA: data_q <= (data_q & lock_q) | (wdata & open_mask);
                RS_DRVA: drva_q <= (drva_q & lock_q) | (wdata & open_mask);
                RS_DRVB: drvb_q <= (drvb_q & lock_q) | (wdata & open_mask);
                RS_LOCK: lock_q <= lock_q | wdata;
                default: ;
            endcase
        end
    end

    // R4: lock bits never fall outside reset
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

    // R4: locked pins keep their direction and data
    a_r4_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((dir_q ^ $past(dir_q)) | (data_q ^ $past(data_q))) & $past(lock_q)) == '0);
endmodule

// File: rtl/gpio_event_unit.sv
// Event detection and routing for the NEV event-capable pins.
// Assumes synchronised inputs. Edge mode keeps a sticky status bit cleared by
// writing 1; level mode tracks the active level. A new edge beats a clear.
module gpio_event_unit
    import gpio_wake_pkg::*;
#(
    parameter int NEV = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NEV-1:0]    wdata,
    input  logic [NEV-1:0]    pin_s,
    output logic [NEV-1:0]    pol_q,
    output logic [NEV-1:0]    trig_q,
    output logic [NEV-1:0]    irq_en_q,
    output logic [NEV-1:0]    smi_en_q,
    output logic [NEV-1:0]    pme_en_q,
    output logic [NEV-1:0]    status_q,
    output logic              irq_o,
    output logic              smi_o,
    output logic              pme_o
);
    reg_sel_e       sel;
    logic [NEV-1:0] active;
    logic [NEV-1:0] clr_mask;

    assign sel      = reg_sel_e'(addr);
    assign active   = pin_s ^ pol_q;
    assign clr_mask = (wr_en && sel == RS_STATUS) ? wdata : '0;

    // Purpose: hold polarity, trigger type and the three routing masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q    <= '0;
            trig_q   <= '0;
            irq_en_q <= '0;
            smi_en_q <= '0;
            pme_en_q <= '0;
        end else if (wr_en) begin
            case (sel)
                RS_POL:   pol_q    <= wdata;
                RS_TRIG:  trig_q   <= wdata;
                RS_IRQEN: irq_en_q <= wdata;
                RS_SMIEN: smi_en_q <= wdata;
                RS_PMEEN: pme_en_q <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NEV; g++) begin : g_src
        logic prev_q;
        logic st_q;

        // Purpose: detect the selected event on one source and keep its status.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                st_q   <= 1'b0;
            end else begin
                prev_q <= active[g];
                if (trig_q[g])
                    st_q <= (st_q & ~clr_mask[g]) | (active[g] & ~prev_q);
                else
                    st_q <= active[g];
            end
        end

        assign status_q[g] = st_q;
    end

    assign irq_o = |(status_q & irq_en_q);
    assign smi_o = |(status_q & smi_en_q);
    assign pme_o = |(status_q & pme_en_q);

    // R7: edge-mode status bits that were set and not cleared stay set
    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & trig_q & ~clr_mask))
                  == $past(status_q & trig_q & ~clr_mask)));

    // R8: level-mode status equals the previous active level
    a_r8_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(trig_q)) == ($past(active) & ~$past(trig_q))));

    // R6: an edge-mode bit can only rise when its source became active
    a_r6_edge_cause: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & $past(trig_q))
                  & ~$past(active & ~g_prev_vec)) == '0);

    logic [NEV-1:0] g_prev_vec;
    for (genvar h = 0; h < NEV; h++) begin : g_prev_tap
        assign g_prev_vec[h] = g_src[h].prev_q;
    end
endmodule

// File: rtl/gpio_wake_bank.sv
// Top of the general-purpose pin bank: synchroniser, lockable output
// configuration, event unit, pad drive and the register read multiplexer.
// Assumes NEV < N or NEV == N; pins at NEV and above are plain I/O only.
module gpio_wake_bank
    import gpio_wake_pkg::*;
#(
    parameter int N   = 16,
    parameter int NEV = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      reg_rdata,
    input  logic [N-1:0]      gpio_in,
    output logic [N-1:0]      gpio_out,
    output logic [N-1:0]      gpio_oe,
    output logic              irq_o,
    output logic              smi_o,
    output logic              pme_o
);
    logic [N-1:0]   pin_s;
    logic [N-1:0]   dir_q, data_q, drva_q, drvb_q, lock_q;
    logic [NEV-1:0] pol_q, trig_q, irq_en_q, smi_en_q, pme_en_q, status_q;
    logic [N-1:0]   od_mask;

    gpio_sync #(.W(N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (gpio_in),
        .sync_o  (pin_s)
    );

    gpio_cfg_regs #(.N(N)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .dir_q  (dir_q),
        .data_q (data_q),
        .drva_q (drva_q),
        .drvb_q (drvb_q),
        .lock_q (lock_q)
    );

    gpio_event_unit #(.NEV(NEV)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata[NEV-1:0]),
        .pin_s    (pin_s[NEV-1:0]),
        .pol_q    (pol_q),
        .trig_q   (trig_q),
        .irq_en_q (irq_en_q),
        .smi_en_q (smi_en_q),
        .pme_en_q (pme_en_q),
        .status_q (status_q),
        .irq_o    (irq_o),
        .smi_o    (smi_o),
        .pme_o    (pme_o)
    );

    for (genvar p = 0; p < N; p++) begin : g_pad
        drv_mode_e mode;
        assign mode = drv_mode_e'({drvb_q[p], drva_q[p]});

        // Purpose: turn direction, drive type and data into pad controls.
        always_comb begin
            gpio_out[p] = 1'b0;
            gpio_oe[p]  = 1'b0;
            od_mask[p]  = 1'b0;
            if (dir_q[p]) begin
                case (mode)
                    DRV_PUSH: begin
                        gpio_out[p] = data_q[p];
                        gpio_oe[p]  = 1'b1;
                    end
                    DRV_OPEN: begin
                        gpio_oe[p] = ~data_q[p];
                        od_mask[p] = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Purpose: select the register addressed by the host for read-back.
    always_comb begin
        case (reg_sel_e'(reg_addr))
            RS_DIR:    reg_rdata = dir_q;
            RS_DATA:   reg_rdata = (dir_q & data_q) | (~dir_q & pin_s);
            RS_DRVA:   reg_rdata = drva_q;
            RS_DRVB:   reg_rdata = drvb_q;
            RS_LOCK:   reg_rdata = lock_q;
            RS_POL:    reg_rdata = N'(pol_q);
            RS_TRIG:   reg_rdata = N'(trig_q);
            RS_IRQEN:  reg_rdata = N'(irq_en_q);
            RS_SMIEN:  reg_rdata = N'(smi_en_q);
            RS_PMEEN:  reg_rdata = N'(pme_en_q);
            RS_STATUS: reg_rdata = N'(status_q);
            default:   reg_rdata = '0;
        endcase
    end

    // R2: input pins never enable their pad driver
    a_r2_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((gpio_oe & ~dir_q) == '0));

    // R3: open-drain pins never drive a high level
    a_r3_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((gpio_out & od_mask) == '0));

    // R9: a raised interrupt output has an enabled status behind it
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((status_q & irq_en_q) != '0));
endmodule

// File: tb/test_gpio_wake_bank.sv
module test_gpio_wake_bank;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] EVM = 16'h7FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out, gpio_oe;
    logic        irq_o, smi_o, pme_o;

    int n_vec = 0;
    int n_bad = 0;

    // bench model
    logic [15:0] m_dir = '0, m_data = '0, m_drva = '0, m_drvb = '0, m_lock = '0;
    logic [15:0] m_pol = '0, m_trig = '0, m_irq = '0, m_smi = '0, m_pme = '0;
    logic [15:0] m_stat = '0, m_prev = '0, m_pins = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_wake_bank i_gpio_wake_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq_o(irq_o),
        .smi_o(smi_o), .pme_o(pme_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_oe();
        return m_dir & ~m_drvb & (~m_drva | (m_drva & ~m_data));
    endfunction

    function automatic logic [15:0] exp_out();
        return m_dir & ~m_drvb & ~m_drva & m_data;
    endfunction

    function automatic logic [15:0] exp_reg(input logic [3:0] a);
        case (a)
            4'd0:  return m_dir;
            4'd1:  return (m_dir & m_data) | (~m_dir & m_pins);
            4'd2:  return m_drva;
            4'd3:  return m_drvb;
            4'd4:  return m_lock;
            4'd5:  return m_pol;
            4'd6:  return m_trig;
            4'd7:  return m_irq;
            4'd8:  return m_smi;
            4'd9:  return m_pme;
            4'd10: return m_stat;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd2, 4'd3, 4'd4: return "R4";
            4'd1:  return "R5";
            4'd10: return "R7";
            4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R10";
            default: return "R1";
        endcase
    endfunction

    // event model after pins and config have been stable long enough
    function automatic void settle();
        logic [15:0] act, rise;
        act    = (m_pins ^ m_pol) & EVM;
        rise   = act & ~m_prev & m_trig;
        m_stat = ((m_stat | rise) & m_trig) | (act & ~m_trig);
        m_prev = act;
    endfunction

    function automatic void model_write(input logic [3:0] a, input logic [15:0] d);
        case (a)
            4'd0:  m_dir  = (m_dir  & m_lock) | (d & ~m_lock);
            4'd1:  m_data = (m_data & m_lock) | (d & ~m_lock);
            4'd2:  m_drva = (m_drva & m_lock) | (d & ~m_lock);
            4'd3:  m_drvb = (m_drvb & m_lock) | (d & ~m_lock);
            4'd4:  m_lock = m_lock | d;
            4'd5:  m_pol  = d & EVM;
            4'd6:  m_trig = d & EVM;
            4'd7:  m_irq  = d & EVM;
            4'd8:  m_smi  = d & EVM;
            4'd9:  m_pme  = d & EVM;
            4'd10: m_stat = m_stat & ~(d & m_trig);
            default: ;
        endcase
        settle();
    endfunction

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        model_write(a, d);
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        gpio_in = v;
        repeat (4) @(negedge clk);
        m_pins = v;
        settle();
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_ports();
        chk("R2 oe", gpio_oe, exp_oe());
        chk("R3 out", gpio_out, exp_out());
        chk("R9 irq", {15'd0, irq_o}, {15'd0, |(m_stat & m_irq)});
        chk("R9 smi", {15'd0, smi_o}, {15'd0, |(m_stat & m_smi)});
        chk("R9 pme", {15'd0, pme_o}, {15'd0, |(m_stat & m_pme)});
    endtask

    task automatic check_reg(input logic [3:0] a);
        logic [15:0] v;
        rd(a, v);
        chk(tag_of(a), v, exp_reg(a));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 oe", gpio_oe, 16'h0);
        chk("R1 out", gpio_out, 16'h0);
        chk("R1 routes", {13'd0, irq_o, smi_o, pme_o}, 16'h0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 reg", v, 16'h0);
        end

        // R2/R3: drive modes
        wr(4'd0, 16'hFF0F);
        wr(4'd1, 16'hA5A5);
        wr(4'd2, 16'h0FF0);
        wr(4'd3, 16'hF000);
        check_ports();

        // R5: data read-back for inputs vs outputs
        set_pins(16'h3C3C);
        check_reg(4'd1);

        // R6: rising edge on pin 0, falling edge on pin 1 (pol=1)
        wr(4'd5, 16'h0002);
        wr(4'd6, 16'h0003);
        wr(4'd10, 16'hFFFF);
        wr(4'd7, 16'h0003);
        set_pins(16'h0002);
        rd(4'd10, v);
        chk("R6 clear base", v & 16'h0003, 16'h0000);
        @(negedge clk);
        gpio_in = 16'h0001;
        repeat (2) @(negedge clk);
        chk("R6 not yet", {15'd0, irq_o}, 16'h0);
        @(negedge clk);
        chk("R6 third edge", {15'd0, irq_o}, 16'h1);
        @(negedge clk);
        m_pins = 16'h0001; settle();
        rd(4'd10, v);
        chk("R6 both edges", v & 16'h0003, 16'h0003);

        // R7: zero write keeps, one write clears, stays cleared
        set_pins(16'h0000);
        wr(4'd10, 16'h0000);
        rd(4'd10, v);
        chk("R7 zero write", v & 16'h0003, 16'h0003);
        wr(4'd10, 16'h0001);
        rd(4'd10, v);
        chk("R7 one write", v & 16'h0003, 16'h0002);

        // R8: level mode follows the active level
        wr(4'd6, 16'h0000);
        set_pins(16'h0010);
        rd(4'd10, v);
        chk("R8 level high", v & 16'h0010, 16'h0010);
        wr(4'd10, 16'h0010);
        rd(4'd10, v);
        chk("R8 clear no effect", v & 16'h0010, 16'h0010);
        set_pins(16'h0000);
        rd(4'd10, v);
        chk("R8 level low", v & 16'h0010, 16'h0000);

        // R10: pin 15 never becomes an event
        wr(4'd6, 16'hFFFF);
        wr(4'd7, 16'hFFFF);
        set_pins(16'h8000);
        rd(4'd10, v);
        chk("R10 no status 15", v & 16'h8000, 16'h0);
        rd(4'd7, v);
        chk("R10 no enable 15", v & 16'h8000, 16'h0);

        // R4: lock pin 3 and 12, then try to change them
        wr(4'd4, 16'h1008);
        wr(4'd4, 16'h0000);
        check_reg(4'd4);
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'h0000);
        wr(4'd3, 16'hFFFF);
        check_reg(4'd0);
        check_reg(4'd3);
        check_ports();

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 3) begin
                set_pins(16'($urandom));
            end else if (op == 3 && ($urandom % 4) == 0) begin
                wr(4'd4, 16'(1 << ($urandom % 16)));
            end else begin
                logic [3:0] a;
                a = 4'($urandom % 12);
                if (a == 4'd4) a = 4'd10;
                wr(a, 16'($urandom));
            end
            check_ports();
            check_reg(4'($urandom % 12));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule